// File: doc/BRIEF.md
# DMA Channel Configuration Register Target

This block is the register front end of a multi-channel DMA engine. A bus master issues single-word read or write requests carrying an address, write data and byte enables. The block decodes each request to one channel and one register. It holds the source address, destination address and interrupt-mask word for every channel. A write to a channel's length register produces a one-cycle start pulse and a byte count for the transfer engine. A write to the channel's reset register produces a one-cycle soft-reset pulse, which also serves as the interrupt acknowledge. The engine reports per-channel busy and result signals, and these come back as a status code when software reads the length register.

The block occupies a 32 KB segment aligned to a 32 KB boundary. Each channel has a 4 KB window inside it. Any access outside the segment, to a missing channel or to an unused offset is answered with an error flag and has no effect. Because of this, the block can also serve as the default target of an interconnect. Each response appears exactly one clock after its request.

Top module: `dma_cfg_regs`

## Requirements
- R1: After reset all stored source, destination and interrupt-mask words are zero, and no response, start pulse or soft-reset pulse is active.
- R2: Every request cycle (req_valid high) yields rsp_valid high on the following cycle, and only then.
- R3: The channel is taken from address bits [14:12] and the register from bits [4:0]. The offsets are 0x00 source, 0x04 destination, 0x08 length/status, 0x0C reset and 0x10 interrupt mask. Address bits [11:5] are not decoded. Source, destination and mask are read/write, and byte enable bit k writes data bits [8k+7:8k].
- R4: A write to offset 0x08 of an idle channel raises that channel's bit of start_o for exactly the next cycle. In that same cycle len_o carries the write data, with the bytes whose enables are clear forced to zero.
- R5: A read of offset 0x08 returns 4 while the channel's busy_i bit is high. Otherwise it returns the channel's 2-bit result code, zero-extended (2 idle, 0 success, 1 read error, 3 write error).
- R6: A write of any value to offset 0x0C raises that channel's bit of soft_rst_o for exactly the next cycle, even while the channel is busy. A read of offset 0x0C is an error.
- R7: irq_o[k] equals irq_raw_i[k] while channel k's mask word is zero, and is low while that word is nonzero.
- R8: While a channel's busy_i bit is high, writes to its source, destination or length register are ignored without an error response, and no start pulse is produced.
- R9: An access whose address bits above bit 14 differ from those of SEG_BASE gets rsp_err high and read data zero, and changes no state.
- R10: An access to a channel index of NUM_CH or above, or to an offset outside the five listed, gets rsp_err high and read data zero, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |
| rsp_err | output | 1 | Error response |
| busy_i | input | NUM_CH | Per-channel busy from the engine |
| result_i | input | 2*NUM_CH | Per-channel 2-bit result code |
| irq_raw_i | input | NUM_CH | Per-channel completion interrupt from the engine |
| irq_o | output | NUM_CH | Masked interrupt lines |
| start_o | output | NUM_CH | One-cycle transfer start pulses |
| len_o | output | 32 | Byte count that goes with a start pulse |
| soft_rst_o | output | NUM_CH | One-cycle channel reset / interrupt acknowledge |
| src_addr_o | output | 32*NUM_CH | Source address per channel, channel k at bits [32k+31:32k] |
| dst_addr_o | output | 32*NUM_CH | Destination address per channel |

## Verification
A wrong stored word is visible on the src_addr_o and dst_addr_o buses in the cycle after the faulty write, and it is also visible on the next read of that register. A fault in the mask state shows up at once on irq_o. A fault in decoding shows up in the response to the same request, one cycle later, as a wrong rsp_err or rsp_rdata, or as a start or reset pulse on the wrong channel. The bench drives random busy, result and interrupt inputs and compares every response, pulse and address bus against a model after each request. A stray write or a missed ignore is therefore detected within one cycle.

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] SEG_BASE = 32'h0004_8000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [3:0]           req_be,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  input  logic [NUM_CH-1:0]    busy_i,
  input  logic [2*NUM_CH-1:0]  result_i,
  input  logic [NUM_CH-1:0]    irq_raw_i,
  output logic [NUM_CH-1:0]    irq_o,
  output logic [NUM_CH-1:0]    start_o,
  output logic [31:0]          len_o,
  output logic [NUM_CH-1:0]    soft_rst_o,
  output logic [32*NUM_CH-1:0] src_addr_o,
  output logic [32*NUM_CH-1:0] dst_addr_o
);
  localparam logic [4:0] OFS_SRC = 5'h00;
  localparam logic [4:0] OFS_DST = 5'h04;
  localparam logic [4:0] OFS_LEN = 5'h08;
  localparam logic [4:0] OFS_RST = 5'h0C;
  localparam logic [4:0] OFS_DIS = 5'h10;

  logic [31:0] src_q [NUM_CH];
  logic [31:0] dst_q [NUM_CH];
  logic [31:0] dis_q [NUM_CH];

  logic [2:0]        ch;
  logic [4:0]        off;
  logic              seg_ok, ch_ok, off_ok, acc_ok, wr_ok;
  logic [NUM_CH-1:0] hit;
  logic              ch_busy;
  logic [31:0]       bemask, rdata_d;

  assign ch      = req_addr[14:12];
  assign off     = req_addr[4:0];
  assign seg_ok  = req_addr[ADDR_W-1:15] == SEG_BASE[ADDR_W-1:15];
  assign ch_ok   = int'(ch) < NUM_CH;
  assign off_ok  = (off == OFS_SRC) || (off == OFS_DST) || (off == OFS_LEN) ||
                   (off == OFS_DIS) || (off == OFS_RST && req_write);
  assign acc_ok  = seg_ok && ch_ok && off_ok;
  assign wr_ok   = req_valid && req_write && acc_ok;
  assign ch_busy = |(hit & busy_i);
  assign bemask  = {{8{req_be[3]}}, {8{req_be[2]}}, {8{req_be[1]}}, {8{req_be[0]}}};

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) hit[i] = (int'(ch) == i);
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i]) begin
        case (off)
          OFS_SRC: rdata_d = src_q[i];
          OFS_DST: rdata_d = dst_q[i];
          OFS_LEN: rdata_d = busy_i[i] ? 32'd4 : {30'd0, result_i[2*i +: 2]};
          OFS_DIS: rdata_d = dis_q[i];
          default: rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        dis_q[i] <= '0;
      end
    end else if (wr_ok) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (hit[i] && !busy_i[i] && off == OFS_SRC)
          src_q[i] <= (src_q[i] & ~bemask) | (req_wdata & bemask);
        if (hit[i] && !busy_i[i] && off == OFS_DST)
          dst_q[i] <= (dst_q[i] & ~bemask) | (req_wdata & bemask);
        if (hit[i] && off == OFS_DIS)
          dis_q[i] <= (dis_q[i] & ~bemask) | (req_wdata & bemask);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      start_o    <= '0;
      soft_rst_o <= '0;
      len_o      <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_err    <= req_valid && !acc_ok;
      rsp_rdata  <= (req_valid && !req_write && acc_ok) ? rdata_d : '0;
      start_o    <= (wr_ok && off == OFS_LEN) ? (hit & ~busy_i) : '0;
      soft_rst_o <= (wr_ok && off == OFS_RST) ? hit : '0;
      if (wr_ok && off == OFS_LEN && !ch_busy)
        len_o <= req_wdata & bemask;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign irq_o[g]             = irq_raw_i[g] && (dis_q[g] == '0);
    assign src_addr_o[32*g +: 32] = src_q[g];
    assign dst_addr_o[32*g +: 32] = dst_q[g];

    p_busy_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i[g] |=> !start_o[g]);
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i[g] |=> ($stable(src_q[g]) && $stable(dst_q[g])));
  end

  p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_start_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));
  p_srst_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(soft_rst_o));
  p_seg_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seg_ok) |=> (rsp_err && rsp_rdata == '0));
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (start_o == '0 && soft_rst_o == '0 && rsp_rdata == '0));
endmodule

// File: tb/tb_dma_cfg_regs.sv
module tb_dma_cfg_regs;
  localparam int CLK_P = 10;
  localparam int NCH = 6;
  localparam logic [31:0] SEG = 32'h0004_8000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_be = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, len_o;
  logic [NCH-1:0] busy_i = 0, irq_raw_i = 0, irq_o, start_o, soft_rst_o;
  logic [2*NCH-1:0] result_i = 0;
  logic [32*NCH-1:0] src_addr_o, dst_addr_o;

  dma_cfg_regs #(.NUM_CH(NCH), .ADDR_W(32), .SEG_BASE(SEG)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] src_m [NCH], dst_m [NCH], dis_m [NCH];
  logic [31:0] len_m = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] d, logic [3:0] be);
    logic [31:0] m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (o & ~m) | (d & m);
  endfunction

  function automatic logic [31:0] mk(int c, logic [4:0] o);
    return SEG | (32'(c) << 12) | 32'(o);
  endfunction

  task automatic check_static(string tag);
    for (int i = 0; i < NCH; i++) begin
      chk({tag, " R7 irq"}, 32'(irq_o[i]), 32'(irq_raw_i[i] && dis_m[i] == 0));
      chk({tag, " R3 srcbus"}, src_addr_o[32*i +: 32], src_m[i]);
      chk({tag, " R3 dstbus"}, dst_addr_o[32*i +: 32], dst_m[i]);
    end
  endtask

  // one request, sampled at the next falling edge
  task automatic access(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] be);
    bit seg_ok, err; int c; logic [4:0] o;
    logic [31:0] erd; logic [NCH-1:0] est, esr;
    c = int'(a[14:12]); o = a[4:0];
    seg_ok = a[31:15] == SEG[31:15];
    err = !seg_ok || c >= NCH ||
          !(o == 5'h00 || o == 5'h04 || o == 5'h08 || o == 5'h10 || (o == 5'h0C && wr));
    erd = 0; est = 0; esr = 0;
    if (!err && !wr) begin
      case (o)
        5'h00: erd = src_m[c];
        5'h04: erd = dst_m[c];
        5'h08: erd = busy_i[c] ? 32'd4 : {30'd0, result_i[2*c +: 2]};
        5'h10: erd = dis_m[c];
        default: erd = 0;
      endcase
    end
    if (!err && wr) begin
      case (o)
        5'h00: if (!busy_i[c]) src_m[c] = mrg(src_m[c], d, be);
        5'h04: if (!busy_i[c]) dst_m[c] = mrg(dst_m[c], d, be);
        5'h08: if (!busy_i[c]) begin est[c] = 1; len_m = mrg(0, d, be); end
        5'h0C: esr[c] = 1;
        5'h10: dis_m[c] = mrg(dis_m[c], d, be);
        default: ;
      endcase
    end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    chk("R2 rsp_valid", 32'(rsp_valid), 1);
    chk(seg_ok ? "R10 err" : "R9 err", 32'(rsp_err), 32'(err));
    chk("R5/R3 rdata", rsp_rdata, erd);
    chk("R4/R8 start", 32'(start_o), 32'(est));
    chk("R6 soft_rst", 32'(soft_rst_o), 32'(esr));
    chk("R4 len", len_o, len_m);
    check_static("post");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin src_m[i] = 0; dst_m[i] = 0; dis_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 start", 32'(start_o), 0);
    chk("R1 soft_rst", 32'(soft_rst_o), 0);
    check_static("R1");
    @(negedge clk);
    chk("R2 idle no rsp", 32'(rsp_valid), 0);

    // R3 registers, partial bytes, undecoded bits [11:5]
    access(1, mk(2, 5'h00), 32'hA5A5_1234, 4'hF);
    access(1, mk(2, 5'h00) | 32'h0000_0FE0, 32'hFFFF_0000, 4'b0100);
    access(0, mk(2, 5'h00), 0, 4'hF);
    access(1, mk(5, 5'h04), 32'h1000_0040, 4'hF);
    access(0, mk(5, 5'h04), 0, 4'hF);
    // R4 start with masked length bytes
    access(1, mk(1, 5'h08), 32'h0000_1F40, 4'b0011);
    access(1, mk(3, 5'h08), 32'h1122_3344, 4'b1010);
    // R5 status codes
    result_i = 12'b11_10_01_00_11_10;
    for (int c = 0; c < NCH; c++) access(0, mk(c, 5'h08), 0, 4'hF);
    busy_i = 6'b000100;
    access(0, mk(2, 5'h08), 0, 4'hF);
    // R8 busy ignores
    access(1, mk(2, 5'h00), 32'hDEAD_BEEF, 4'hF);
    access(1, mk(2, 5'h04), 32'hDEAD_BEEF, 4'hF);
    access(1, mk(2, 5'h08), 32'h0000_0100, 4'hF);
    // R6 reset works while busy, read is error
    access(1, mk(2, 5'h0C), 32'h0, 4'h0);
    access(0, mk(2, 5'h0C), 0, 4'hF);
    busy_i = 0;
    // R7 mask
    irq_raw_i = '1;
    access(1, mk(4, 5'h10), 32'h0000_0100, 4'b0010);
    access(1, mk(4, 5'h10), 32'h0, 4'hF);
    // R9 / R10 errors
    access(1, 32'h0005_0000 | 32'h08, 32'h40, 4'hF);
    access(0, 32'h0004_0000, 0, 4'hF);
    access(1, mk(6, 5'h08), 32'h40, 4'hF);
    access(1, mk(7, 5'h00), 32'h40, 4'hF);
    access(1, mk(0, 5'h14), 32'h40, 4'hF);
    access(0, mk(0, 5'h02), 0, 4'hF);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a; logic [4:0] o; int k;
      busy_i = NCH'($urandom);
      result_i = (2*NCH)'($urandom);
      irq_raw_i = NCH'($urandom);
      k = int'($urandom_range(0, 6));
      case (k)
        0: o = 5'h00; 1: o = 5'h04; 2: o = 5'h08; 3: o = 5'h0C; 4: o = 5'h10;
        default: o = 5'($urandom);
      endcase
      a = mk(int'($urandom_range(0, 7)), o) | (32'($urandom) & 32'h0000_0FE0);
      if ($urandom_range(0, 15) == 0) a = a ^ (32'h1 << $urandom_range(15, 31));
      access(1'($urandom), a, $urandom, 4'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        chk("R2 gap", 32'(rsp_valid), 0);
        chk("R4 gap start", 32'(start_o), 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule